// File: doc/BRIEF.md
# Least-Occupied-Column Input Arbiter

This block is the scheduler for one input port of a buffered crossbar. It keeps a count of the cells waiting in each of the port's virtual output queues (one queue per output), based on arrival notices from the line card. Once in every cell time it picks one queue whose cell may move into its crosspoint buffer. A queue can be picked only if it holds cells and its crosspoint buffer in this input's row has room.

Among the queues that can be picked, the arbiter favours the one whose output column of crosspoint buffers holds the fewest cells. Each column's fill level arrives as a one-hot vector. The arbiter zeroes the vectors of queues that cannot be picked and ORs the remaining vectors together bit by bit. The lowest set bit gives the minimum level. Every queue still set at that level is a candidate. When there are several candidates, a rotating-pointer priority encoder chooses between them.

The decision runs as a pipeline across the cycles of one cell time. The arbiter sends the chosen index back to the line card and takes one cell off that queue's count.

Top module: `mocr_input_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt_vld` is 0. After reset, all queue counts are zero and the rotating pointer is 0.
- R2: An arrival (`arr_vld`=1) with `arr_idx` below `N_VOQ` adds one to that queue's count. An arrival with `arr_idx` at or above `N_VOQ` changes no count and leads to no grant.
- R3: A queue is eligible only when its count is non-zero and its bit in `xp_free` is 1, both as sampled in the first cycle (phase 0) of a cell time.
- R4: Column j's fill level k is given by bit `j*(N_VOQ+1)+k` of `col_occ` (one-hot). The grant goes to an eligible queue with the lowest fill level.
- R5: When several eligible queues share the lowest level, the winner is the first one found searching upward from the pointer, wrapping from `N_VOQ-1` to 0. After a grant to queue j, the pointer becomes (j+1) mod `N_VOQ`.
- R6: Cell times are `CELL_CYC` cycles long, counted from reset release. At most one grant is issued per cell time. It is a single-cycle pulse in phase 5, the sixth cycle of the cell time.
- R7: Each grant removes one cell from the granted queue's count. Once a queue's count reaches zero, that queue gets no further grants.
- R8: If no queue is eligible, no grant is issued and the pointer does not move.
- R9: If an arrival for queue j comes in the same cycle as a grant to queue j, the count of queue j is unchanged.
- R10: A grant is `gnt_vld`=1 with the 5-bit queue index on `gnt_idx`. `gnt_idx` reads 0 whenever `gnt_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_vld | input | 1 | Cell arrival notice from line card |
| arr_idx | input | 5 | Queue index of the arrival |
| xp_free | input | 24 | Per-output room in this row's crosspoint buffers |
| col_occ | input | 600 | One-hot fill level of each output column, 25 bits per column |
| gnt_vld | output | 1 | Grant pulse |
| gnt_idx | output | 5 | Index of the granted queue |

## Verification
The assertions rely on these input assumptions:
- Every row of `col_occ` is one-hot.
- The line card never lets a count overflow; it sends an arrival only while the queue holds fewer than four cells.
- Grants go only to queues whose count was non-zero.

The stimulus stays within these limits. It builds `col_occ` from integer levels, keeps every count at three or below, and issues short bursts of arrivals only while no queue is eligible. Because of this, no grant falls outside the cell times the bench observes. The bench's reference model tracks counts, the pointer, the levels and the free mask, and predicts each grant.

// File: rtl/mocr_pkg.sv
`timescale 1ns/1ps
package mocr_pkg;
  // pipeline phase assignments inside one cell time
  localparam int unsigned PH_MASK   = 0;
  localparam int unsigned PH_LEVEL  = 1;
  localparam int unsigned PH_PPE_A  = 2;
  localparam int unsigned PH_PPE_B  = 3;
  localparam int unsigned PH_PPE_C  = 4;
  localparam int unsigned PH_GRANT  = 5;
  localparam int unsigned MIN_CELL_CYC = 6;
endpackage

// File: rtl/mocr_voq_count.sv
`timescale 1ns/1ps
module mocr_voq_count #(
  parameter int unsigned N_VOQ = 24,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_vld,
  input  logic [IDX_W-1:0] arr_idx,
  input  logic             dec_vld,
  input  logic [IDX_W-1:0] dec_idx,
  output logic [N_VOQ-1:0] req
);
  logic [CNT_W-1:0] cnt_q [N_VOQ];
  logic [CNT_W-1:0] cnt_d [N_VOQ];
  logic [N_VOQ-1:0] cnt_en;

  for (genvar j = 0; j < N_VOQ; j++) begin : g_entry
    logic inc, dec;
    always_comb begin
      inc       = arr_vld && (arr_idx == IDX_W'(j));
      dec       = dec_vld && (dec_idx == IDX_W'(j));
      cnt_en[j] = inc ^ dec;
      cnt_d[j]  = inc ? cnt_q[j] + 1'b1 : cnt_q[j] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[j] <= '0;
      else if (cnt_en[j]) cnt_q[j] <= cnt_d[j];
    end

    assign req[j] = |cnt_q[j];
  end
endmodule

// File: rtl/mocr_min_level.sv
`timescale 1ns/1ps
module mocr_min_level #(
  parameter int unsigned N_VOQ = 24,
  parameter int unsigned LVL_W = 25
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_mask,
  input  logic                   ld_cand,
  input  logic [N_VOQ-1:0]       elig,
  input  logic [N_VOQ*LVL_W-1:0] occ,
  output logic [N_VOQ-1:0]       cand
);
  logic [LVL_W-1:0] masked_q [N_VOQ];
  logic [LVL_W-1:0] masked_d [N_VOQ];
  logic [LVL_W-1:0] lvl_or;
  logic [LVL_W-1:0] lvl_pick;
  logic [N_VOQ-1:0] cand_d, cand_q;

  // stage 1: zero the occupancy rows of ineligible queues
  for (genvar j = 0; j < N_VOQ; j++) begin : g_mask
    always_comb masked_d[j] = elig[j] ? occ[j*LVL_W +: LVL_W] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       masked_q[j] <= '0;
      else if (ld_mask) masked_q[j] <= masked_d[j];
    end
  end

  // stage 2: OR-reduce per level, isolate the lowest populated level
  always_comb begin
    lvl_or = '0;
    for (int j = 0; j < N_VOQ; j++) lvl_or = lvl_or | masked_q[j];
    lvl_pick = lvl_or & ((~lvl_or) + LVL_W'(1));
  end

  for (genvar j = 0; j < N_VOQ; j++) begin : g_cand
    assign cand_d[j] = |(masked_q[j] & lvl_pick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= '0;
    else if (ld_cand) cand_q <= cand_d;
  end

  assign cand = cand_q;
endmodule

// File: rtl/mocr_rr_ppe.sv
`timescale 1ns/1ps
module mocr_rr_ppe #(
  parameter int unsigned N_VOQ = 24,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             en_c,
  input  logic [N_VOQ-1:0] req,
  input  logic [IDX_W-1:0] ptr,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx
);
  // stage A: split requests at the pointer
  logic [N_VOQ-1:0] hi_d, hi_a, all_a;
  always_comb begin
    for (int j = 0; j < N_VOQ; j++) hi_d[j] = req[j] && (IDX_W'(j) >= ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_a  <= '0;
      all_a <= '0;
    end else if (en_a) begin
      hi_a  <= hi_d;
      all_a <= req;
    end
  end

  // stage B: two plain priority encoders
  logic             hi_any_d, lo_any_d, hi_any_b, lo_any_b;
  logic [IDX_W-1:0] hi_idx_d, lo_idx_d, hi_idx_b, lo_idx_b;
  always_comb begin
    hi_any_d = 1'b0;
    hi_idx_d = '0;
    lo_any_d = 1'b0;
    lo_idx_d = '0;
    for (int j = N_VOQ - 1; j >= 0; j--) begin
      if (hi_a[j]) begin
        hi_any_d = 1'b1;
        hi_idx_d = IDX_W'(j);
      end
      if (all_a[j]) begin
        lo_any_d = 1'b1;
        lo_idx_d = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_any_b <= 1'b0;
      lo_any_b <= 1'b0;
      hi_idx_b <= '0;
      lo_idx_b <= '0;
    end else if (en_b) begin
      hi_any_b <= hi_any_d;
      lo_any_b <= lo_any_d;
      hi_idx_b <= hi_idx_d;
      lo_idx_b <= lo_idx_d;
    end
  end

  // stage C: upper half wins, else wrap to the lowest request
  logic             win_vld_q;
  logic [IDX_W-1:0] win_idx_q, win_idx_d;
  always_comb win_idx_d = hi_any_b ? hi_idx_b : lo_idx_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_vld_q <= 1'b0;
      win_idx_q <= '0;
    end else if (en_c) begin
      win_vld_q <= lo_any_b;
      win_idx_q <= win_idx_d;
    end
  end

  assign win_vld = win_vld_q;
  assign win_idx = win_idx_q;
endmodule

// File: rtl/mocr_input_arbiter.sv
`timescale 1ns/1ps
module mocr_input_arbiter #(
  parameter int unsigned N_VOQ    = 24,
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned CELL_CYC = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            arr_vld,
  input  logic [$clog2(N_VOQ)-1:0]        arr_idx,
  input  logic [N_VOQ-1:0]                xp_free,
  input  logic [N_VOQ*(N_VOQ+1)-1:0]      col_occ,
  output logic                            gnt_vld,
  output logic [$clog2(N_VOQ)-1:0]        gnt_idx
);
  import mocr_pkg::*;

  localparam int unsigned IDX_W = $clog2(N_VOQ);
  localparam int unsigned LVL_W = N_VOQ + 1;
  localparam int unsigned PH_W  = $clog2(CELL_CYC);

  // cell-time phase counter
  logic [PH_W-1:0] phase_q, phase_d;
  always_comb phase_d = (phase_q == PH_W'(CELL_CYC - 1)) ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  logic st_mask, st_level, st_a, st_b, st_c, st_grant;
  always_comb begin
    st_mask  = (phase_q == PH_W'(PH_MASK));
    st_level = (phase_q == PH_W'(PH_LEVEL));
    st_a     = (phase_q == PH_W'(PH_PPE_A));
    st_b     = (phase_q == PH_W'(PH_PPE_B));
    st_c     = (phase_q == PH_W'(PH_PPE_C));
    st_grant = (phase_q == PH_W'(PH_GRANT));
  end

  logic [N_VOQ-1:0] req_vec, elig_vec, cand_vec;
  logic             win_vld, gnt_fire;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] rr_ptr_q, rr_ptr_d;

  assign elig_vec = req_vec & xp_free;
  assign gnt_fire = win_vld & st_grant;

  mocr_voq_count #(.N_VOQ(N_VOQ), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .arr_vld(arr_vld), .arr_idx(arr_idx),
    .dec_vld(gnt_fire), .dec_idx(win_idx),
    .req(req_vec)
  );

  mocr_min_level #(.N_VOQ(N_VOQ), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n),
    .ld_mask(st_mask), .ld_cand(st_level),
    .elig(elig_vec), .occ(col_occ),
    .cand(cand_vec)
  );

  mocr_rr_ppe #(.N_VOQ(N_VOQ), .IDX_W(IDX_W)) u_ppe (
    .clk(clk), .rst_n(rst_n),
    .en_a(st_a), .en_b(st_b), .en_c(st_c),
    .req(cand_vec), .ptr(rr_ptr_q),
    .win_vld(win_vld), .win_idx(win_idx)
  );

  // rotating pointer: one past the last winner
  always_comb rr_ptr_d = (win_idx == IDX_W'(N_VOQ - 1)) ? '0 : win_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rr_ptr_q <= '0;
    else if (gnt_fire) rr_ptr_q <= rr_ptr_d;
  end

  assign gnt_vld = gnt_fire;
  assign gnt_idx = gnt_fire ? win_idx : '0;
endmodule

// File: rtl/mocr_input_arbiter_chk.sv
`timescale 1ns/1ps
module mocr_input_arbiter_chk #(
  parameter int unsigned N_VOQ    = 24,
  parameter int unsigned CELL_CYC = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(CELL_CYC)-1:0] phase_q,
  input logic [$clog2(N_VOQ)-1:0]   rr_ptr_q,
  input logic [N_VOQ-1:0]           req,
  input logic                       gnt_vld,
  input logic [$clog2(N_VOQ)-1:0]   gnt_idx
);
  localparam int unsigned IDX_W = $clog2(N_VOQ);
  localparam int unsigned PH_W  = $clog2(CELL_CYC);

  logic [N_VOQ-1:0] req_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= req;
  end

  always_comb begin
    if (!rst_n) AST_RST_QUIET: assert (!gnt_vld); // R1
  end

  AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |=> !gnt_vld); // R6
  AST_GNT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (phase_q == PH_W'(mocr_pkg::PH_GRANT))); // R6
  AST_GNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (gnt_idx < IDX_W'(N_VOQ))); // R10
  AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt_idx == '0)); // R10
  AST_GNT_HAD_CELLS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req_d[gnt_idx]); // R7
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |=> (rr_ptr_q == (($past(gnt_idx) == IDX_W'(N_VOQ - 1)) ? '0 : $past(gnt_idx) + 1'b1))); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |=> $stable(rr_ptr_q)); // R8
endmodule

bind mocr_input_arbiter mocr_input_arbiter_chk #(.N_VOQ(N_VOQ), .CELL_CYC(CELL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .rr_ptr_q(rr_ptr_q),
  .req(req_vec), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
);

// File: tb/sim_mocr_input_arbiter.sv
`timescale 1ns/1ps
module sim_mocr_input_arbiter;
  localparam int N   = 24;
  localparam int LVL = N + 1;
  localparam int CYC = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             arr_vld;
  logic [4:0]       arr_idx;
  logic [N-1:0]     xp_free;
  logic [N*LVL-1:0] col_occ;
  logic             gnt_vld;
  logic [4:0]       gnt_idx;

  always #10 clk = ~clk;

  mocr_input_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_idx(arr_idx),
    .xp_free(xp_free), .col_occ(col_occ), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  int n_chk = 0, n_bad = 0, stray = 0, bcyc = 0;
  bit in_window = 0, done = 0;
  int m_cnt [N];
  int m_ptr;
  int lvl [N];

  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  always @(negedge clk) if (rst_n && !in_window && gnt_vld) stray++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_occ();
    col_occ = '0;
    for (int j = 0; j < N; j++) col_occ[j*LVL + lvl[j]] = 1'b1;
  endtask

  function automatic int ref_pick();
    int minl = LVL + 1;
    for (int j = 0; j < N; j++)
      if (m_cnt[j] > 0 && xp_free[j] && lvl[j] < minl) minl = lvl[j];
    if (minl > LVL) return -1;
    for (int k = 0; k < N; k++) begin
      int j = (m_ptr + k) % N;
      if (m_cnt[j] > 0 && xp_free[j] && lvl[j] == minl) return j;
    end
    return -1;
  endfunction

  task automatic align();
    while (bcyc % CYC != 0) @(negedge clk);
  endtask

  task automatic push(input int idx);
    @(negedge clk);
    arr_vld = 1'b1;
    arr_idx = 5'(idx);
    @(negedge clk);
    arr_vld = 1'b0;
    if (idx < N) m_cnt[idx]++;
  endtask

  // one full cell time; inj >= 0 sends an arrival in the grant cycle
  task automatic cell_check(input int inj, input string tag);
    int exp, pulses, seen, off;
    pulses = 0; seen = -1; off = -1;
    align();
    exp = ref_pick();
    in_window = 1;
    for (int k = 1; k <= CYC; k++) begin
      @(negedge clk);
      if (gnt_vld) begin
        pulses++;
        seen = int'(gnt_idx);
        off  = k;
      end
      if (k == 5 && inj >= 0) begin
        arr_vld = 1'b1;
        arr_idx = 5'(inj);
      end
      if (k == 6) arr_vld = 1'b0;
    end
    in_window = 0;
    if (exp < 0) begin
      check(pulses == 0, {tag, " no grant"}, pulses, 0);
    end else begin
      check(pulses == 1, {tag, " one grant"}, pulses, 1);
      check(seen == exp, {tag, " grant index"}, seen, exp);
      check(off == 5, {tag, " grant phase"}, off, 5);
      if (inj != exp) m_cnt[exp]--;
      m_ptr = (exp + 1) % N;
    end
    if (inj >= 0 && inj != exp) m_cnt[inj]++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; arr_vld = 1'b0; arr_idx = '0; xp_free = '1;
    for (int j = 0; j < N; j++) begin lvl[j] = 0; m_cnt[j] = 0; end
    m_ptr = 0;
    set_occ();
    repeat (3) @(negedge clk);
    check(gnt_vld == 1'b0, "R1 grant low in reset", int'(gnt_vld), 0);
    rst_n = 1'b1;
    cell_check(-1, "R1 R8 idle after reset");
  endtask

  task automatic t_first_grants();
    push(3); push(1);
    cell_check(-1, "R1 pointer starts at 0");
    cell_check(-1, "R2 R10 second queue");
    cell_check(-1, "R7 drained");
  endtask

  task automatic t_min_level();
    lvl[2] = 3; lvl[7] = 1; lvl[10] = 2;
    set_occ();
    push(2); push(7); push(10);
    cell_check(-1, "R4 lowest level");
    cell_check(-1, "R4 next level");
    cell_check(-1, "R4 highest level");
    cell_check(-1, "R8 none left");
  endtask

  task automatic t_round_robin();
    for (int j = 0; j < N; j++) lvl[j] = 0;
    set_occ();
    push(1); push(4); push(20);
    cell_check(-1, "R5 tie a");
    cell_check(-1, "R5 tie b");
    cell_check(-1, "R5 tie wrap");
    push(22); push(23); push(0);
    cell_check(-1, "R5 tie c");
    cell_check(-1, "R5 tie top");
    cell_check(-1, "R5 wrap to zero");
  endtask

  task automatic t_blocked();
    xp_free[5] = 1'b0;
    push(5);
    cell_check(-1, "R3 full crosspoint blocks");
    cell_check(-1, "R3 still blocked");
    xp_free[5] = 1'b1;
    cell_check(-1, "R3 released");
    lvl[12] = 0; lvl[13] = 4;
    set_occ();
    xp_free[12] = 1'b0;
    push(12); push(13);
    cell_check(-1, "R3 R4 blocked lower level skipped");
    cell_check(-1, "R3 blocked again");
    xp_free[12] = 1'b1;
    cell_check(-1, "R3 lower level freed");
  endtask

  task automatic t_out_of_range();
    push(25); push(31);
    cell_check(-1, "R2 out-of-range ignored");
  endtask

  task automatic t_multi();
    push(6); push(6); push(6);
    cell_check(-1, "R7 count 3");
    cell_check(-1, "R7 count 2");
    cell_check(-1, "R7 count 1");
    cell_check(-1, "R7 empty");
  endtask

  task automatic t_same_cycle();
    push(9);
    cell_check(9, "R9 arrival with grant");
    cell_check(-1, "R9 count kept");
    cell_check(-1, "R9 then empty");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_grants();
    t_min_level();
    t_round_robin();
    t_blocked();
    t_out_of_range();
    t_multi();
    t_same_cycle();
    check(stray == 0, "R6 grant outside observed phase", stray, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule